// File: doc/BRIEF.md
# Gradient-Step Channel Estimate Updater

This block refines a multiuser channel estimate by one steepest-descent step each time it is started. The estimate Y is a matrix of 2K rows by N columns of signed 16-bit fixed-point values. The step computes Y_new = Y_old - mu*(A*Y_old - C). A is the 2K-by-2K autocorrelation matrix of the training bits. It holds signed 8-bit integers and is read from outside through an address/data port. C is the 16-bit cross-correlation matrix. mu is a power of two, so the multiply by mu becomes an arithmetic right shift. The block computes the real part only. A second identical instance handles the imaginary part, because A is real and no complex products arise.

The matrix product is folded onto N lanes, one per column. All N lanes take the same row of A and the same row of Y_old. Each lane accumulates one output element over 2K cycles. In the last of those cycles it forms the subtract, shift and saturate, and writes the result into the spare bank of a two-bank Y store. When the pass ends the banks swap. Every product therefore sees only old values, and a full pass takes 4K^2 cycles.

Software-side access works as follows. Y and C are written through a valid/ready load port while the block is idle. Any Y element can be read back at any time through a combinational read port. Back-pressure rule: a load beat transfers on a rising edge only when `ld_valid` and `ld_ready` are both high. `ld_ready` is low for the whole pass, and a beat offered then is neither taken nor queued.

Top module: `est_grad_step`

## Requirements
- R1: After reset `busy` and `done` are 0 and `ld_ready` is 1.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle. `busy` stays high for exactly 4K^2 cycles. `done` is then high for exactly one cycle, with `busy` low.
- R3: `start` while `busy` is high is ignored. The pass length and the result are unchanged, and no second pass follows.
- R4: `ld_ready` is low during a pass, and a load beat offered then changes no stored value. When idle, a beat with `ld_sel`=0 writes Y(`ld_row`,`ld_col`) of the current bank, and a beat with `ld_sel`=1 writes C(`ld_row`,`ld_col`).
- R5: For each row j and column k, the term for i is t_i = sat16((A(j,i)*Y_old(i,k)) >>> TRUNC_SH). The sum s is accumulated with i ascending from 0, saturating after each addition. The result is Y_new(j,k) = sat16(Y_old(j,k) - (sat16(s - C(j,k)) >>> MU_SH)).
- R6: Every addition and subtraction clamps to the range -32768..32767, and a truncated product clamps to the same range.
- R7: The shifts are arithmetic, so a negative value rounds toward minus infinity. For example, -1 >>> MU_SH stays -1.
- R8: During a pass `rbb_row` is the output row j and `rbb_col` is the term index i. The index advances with i fastest, from (0,0) to (2K-1,2K-1), one pair per cycle, and `rbb_data` is taken in the same cycle.
- R9: `rd_data` returns Y(`rd_row`,`rd_col`) of the current bank. After `done` this is the new estimate, and a following pass uses it as Y_old.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a pass when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be taken |
| ld_sel | input | 1 | 0 = Y element, 1 = C element |
| ld_row | input | $clog2(2K) | Row of the loaded element |
| ld_col | input | clog2(N) | Column of the loaded element |
| ld_data | input | 16 | Loaded value |
| rbb_row | output | $clog2(2K) | Autocorrelation row address |
| rbb_col | output | $clog2(2K) | Autocorrelation column address |
| rbb_data | input | 8 | Autocorrelation element, signed |
| rd_row | input | $clog2(2K) | Read row |
| rd_col | input | clog2(N) | Read column |
| rd_data | output | 16 | Y element of the current bank |

## Verification
The assertions assume that `rst` is held for at least one clock and that `start` is only a request. Under that assumption the address walk, the pass length and the single done pulse follow from the block alone. The assertions place no limit on how often `start` is raised during a pass. The stimulus deliberately raises it mid-pass and also offers a load beat then, so the ignore rules are exercised. All other inputs change only on falling edges. `rbb_data` is driven combinationally from the bench's own matrix at the address the block presents. This matches the same-cycle read the block expects.

// File: rtl/est_grad_pkg.sv
package est_grad_pkg;
  localparam int DW = 16;   // estimate and correlation word width
  localparam int AW = 40;   // working width before clamping

  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -AW'(64'sd1 <<< (DW-1));

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else return v[DW-1:0];
  endfunction
endpackage

// File: rtl/sdu_seq.sv
module sdu_seq #(
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] row,
  output logic [RW-1:0] term,
  output logic          first,
  output logic          wr_en,
  output logic          swap
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic last_term;
  assign last_term = (term == LAST);
  assign first = (term == '0);
  assign wr_en = busy && last_term;
  assign swap  = wr_en && (row == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      row  <= '0;
      term <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          row  <= '0;
          term <= '0;
        end
      end else if (last_term) begin
        term <= '0;
        if (row == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          row  <= '0;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        term <= term + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdu_lane.sv
module sdu_lane
  import est_grad_pkg::*;
#(
  parameter int RBB_W    = 8,
  parameter int TRUNC_SH = 4,
  parameter int MU_SH    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [RBB_W-1:0] a_in,
  input  logic signed [DW-1:0]    y_term,
  input  logic signed [DW-1:0]    y_self,
  input  logic signed [DW-1:0]    c_in,
  output logic signed [DW-1:0]    y_new
);
  logic signed [AW-1:0] prod;
  logic signed [DW-1:0] term, base, sum, diff, step;
  logic signed [DW-1:0] acc;

  always_comb begin
    prod  = AW'(a_in) * AW'(y_term);
    term  = clamp(prod >>> TRUNC_SH);
    base  = first ? '0 : acc;
    sum   = clamp(AW'(base) + AW'(term));
    diff  = clamp(AW'(sum) - AW'(c_in));
    step  = diff >>> MU_SH;
    y_new = clamp(AW'(y_self) - AW'(step));
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= sum;
  end
endmodule

// File: rtl/est_grad_step.sv
module est_grad_step
  import est_grad_pkg::*;
#(
  parameter int K_USERS  = 4,
  parameter int N_COLS   = 8,
  parameter int RBB_W    = 8,
  parameter int TRUNC_SH = 4,
  parameter int MU_SH    = 10,
  localparam int ROWS = 2 * K_USERS,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic                    ld_sel,
  input  logic [RW-1:0]           ld_row,
  input  logic [CW-1:0]           ld_col,
  input  logic signed [DW-1:0]    ld_data,
  output logic [RW-1:0]           rbb_row,
  output logic [RW-1:0]           rbb_col,
  input  logic signed [RBB_W-1:0] rbb_data,
  input  logic [RW-1:0]           rd_row,
  input  logic [CW-1:0]           rd_col,
  output logic signed [DW-1:0]    rd_data
);
  logic signed [DW-1:0] ymem [2][ROWS][N_COLS];
  logic signed [DW-1:0] cmem [ROWS][N_COLS];
  logic signed [DW-1:0] y_new [N_COLS];
  logic cur, first, wr_en, swap, take;

  sdu_seq #(.ROWS(ROWS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .row(rbb_row), .term(rbb_col), .first(first), .wr_en(wr_en), .swap(swap)
  );

  generate
    for (genvar k = 0; k < N_COLS; k++) begin : g_lane
      sdu_lane #(.RBB_W(RBB_W), .TRUNC_SH(TRUNC_SH), .MU_SH(MU_SH)) u_lane (
        .clk(clk), .rst(rst), .en(busy), .first(first),
        .a_in(rbb_data),
        .y_term(ymem[cur][rbb_col][k]),
        .y_self(ymem[cur][rbb_row][k]),
        .c_in(cmem[rbb_row][k]),
        .y_new(y_new[k])
      );
    end
  endgenerate

  assign ld_ready = !busy;
  assign take     = ld_valid && ld_ready;
  assign rd_data  = ymem[cur][rd_row][rd_col];

  always_ff @(posedge clk) begin
    if (rst) cur <= 1'b0;
    else if (swap) cur <= ~cur;
  end

  always_ff @(posedge clk) begin
    if (take && !ld_sel) ymem[cur][ld_row][ld_col] <= ld_data;
    if (wr_en) begin
      for (int k = 0; k < N_COLS; k++) ymem[~cur][rbb_row][k] <= y_new[k];
    end
  end

  always_ff @(posedge clk) begin
    if (take && ld_sel) cmem[ld_row][ld_col] <= ld_data;
  end
endmodule

// File: rtl/est_grad_step_chk.sv
module est_grad_step_chk #(
  parameter int ROWS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int TOTAL = ROWS * ROWS
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ld_ready,
  input logic [RW-1:0] rbb_row,
  input logic [RW-1:0] rbb_col
);
  int unsigned run_len;
  always_ff @(posedge clk) begin
    if (rst) run_len <= 0;
    else run_len <= busy ? run_len + 1 : 0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == TOTAL));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  rise_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R4
  no_load_in_pass_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld_ready);

  // R8
  term_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && rbb_col != '0) |->
      (rbb_col == $past(rbb_col) + 1'b1 && rbb_row == $past(rbb_row)));

  // R8
  pass_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rbb_row == '0 && rbb_col == '0));
endmodule

bind est_grad_step est_grad_step_chk #(.ROWS(2 * K_USERS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ld_ready(ld_ready), .rbb_row(rbb_row), .rbb_col(rbb_col)
);

// File: tb/tb_est_grad_step.sv
`timescale 1ns/100ps
module tb_est_grad_step;
  localparam int K = 2, N = 2, ROWS = 2 * K, TS = 2, MU = 2;
  localparam int TOTAL = ROWS * ROWS;
  localparam int RW = $clog2(ROWS), CW = $clog2(N);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, ld_ready;
  logic ld_valid = 1'b0, ld_sel = 1'b0;
  logic [RW-1:0] ld_row = '0, rd_row = '0, rbb_row, rbb_col;
  logic [CW-1:0] ld_col = '0, rd_col = '0;
  logic signed [15:0] ld_data = '0, rd_data;
  logic signed [7:0] rbb_data;

  int a_m [ROWS][ROWS];
  int y_m [ROWS][N];
  int c_m [ROWS][N];
  int e_m [ROWS][N];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign rbb_data = 8'(a_m[rbb_row][rbb_col]);

  est_grad_step #(.K_USERS(K), .N_COLS(N), .RBB_W(8), .TRUNC_SH(TS), .MU_SH(MU)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .rbb_row(rbb_row), .rbb_col(rbb_col),
    .rbb_data(rbb_data), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  // y_base, y_step, a_base, c_base
  localparam logic [63:0] VEC [4] = '{
    {16'd100,   16'd250,  16'd3,   16'd500},
    {16'hF000,  16'd1200, 16'd90,  16'hFC18},
    {16'd30000, 16'd1000, 16'd127, 16'd0},
    {16'd0,     16'd0,    16'd0,   16'd1}
  };

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int s16(input int v);
    return int'($signed(16'(v)));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model();
    for (int j = 0; j < ROWS; j++)
      for (int k = 0; k < N; k++) begin
        int s;
        s = 0;
        for (int i = 0; i < ROWS; i++) begin
          int t;
          t = sat((longint'(a_m[j][i]) * y_m[i][k]) >>> TS);
          s = sat(longint'(s) + t);
        end
        e_m[j][k] = sat(longint'(y_m[j][k]) - (sat(longint'(s) - c_m[j][k]) >>> MU));
      end
  endtask

  task automatic load_all();
    for (int j = 0; j < ROWS; j++)
      for (int k = 0; k < N; k++)
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          ld_valid = 1'b1; ld_sel = s[0];
          ld_row = RW'(j); ld_col = CW'(k);
          ld_data = 16'(s == 0 ? y_m[j][k] : c_m[j][k]);
        end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic read_y(input int j, input int k, output int v);
    rd_row = RW'(j); rd_col = CW'(k);
    #1;
    v = int'(rd_data);
  endtask

  task automatic compare_all(input string req);
    for (int j = 0; j < ROWS; j++)
      for (int k = 0; k < N; k++) begin
        int v;
        read_y(j, k, v);
        chk(req, v, e_m[j][k]);
      end
  endtask

  task automatic run_pass(input bit poke_start, input bit poke_load);
    int nb;
    bit addr_ok, ready_ok;
    nb = 0; addr_ok = 1'b1; ready_ok = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy && nb < 1000) begin
      if (int'(rbb_row) != nb / ROWS || int'(rbb_col) != nb % ROWS) addr_ok = 1'b0;
      if (ld_ready) ready_ok = 1'b0;
      start = (poke_start && nb == 3);
      if (poke_load && nb == 5) begin
        ld_valid = 1'b1; ld_sel = 1'b0; ld_row = '0; ld_col = '0; ld_data = 16'h1234;
      end else ld_valid = 1'b0;
      nb++;
      @(negedge clk);
    end
    start = 1'b0; ld_valid = 1'b0;
    chk("R2 busy length", nb, TOTAL);
    chk("R2 done after pass", int'(done), 1);
    chk("R8 address walk", int'(addr_ok), 1);
    chk("R4 ld_ready low in pass", int'(ready_ok), 1);
    @(negedge clk);
    chk("R2 done one cycle", int'(done), 0);
  endtask

  task automatic fill(input logic [63:0] v);
    int yb, ys, ab, cb;
    yb = s16(int'(v[63:48])); ys = s16(int'(v[47:32]));
    ab = s16(int'(v[31:16])); cb = s16(int'(v[15:0]));
    for (int j = 0; j < ROWS; j++) begin
      for (int i = 0; i < ROWS; i++) a_m[j][i] = int'($signed(8'(ab + 17 * j - 23 * i)));
      for (int k = 0; k < N; k++) begin
        y_m[j][k] = s16(yb + j * ys - k * (ys / 2 + 7));
        c_m[j][k] = s16(cb + 301 * j - 57 * k);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int j = 0; j < ROWS; j++)
      for (int i = 0; i < ROWS; i++) a_m[j][i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ld_ready", int'(ld_ready), 1);
    rst = 1'b0;

    // table of vectors: two chained passes each (R5, R6, R9)
    for (int t = 0; t < 4; t++) begin
      int v;
      fill(VEC[t]);
      load_all();
      read_y(1, 1, v);
      chk("R4 R9 loaded value readable", v, y_m[1][1]);
      model();
      run_pass(1'b0, 1'b0);
      compare_all("R5 first pass");
      y_m = e_m;
      model();
      run_pass(1'b0, 1'b0);
      compare_all("R9 chained pass uses new bank");
    end

    // R7: zero estimate, C=1 gives diff -1, step -1, result +1
    for (int j = 0; j < ROWS; j++)
      for (int k = 0; k < N; k++) begin y_m[j][k] = 0; c_m[j][k] = 1; end
    load_all();
    run_pass(1'b0, 1'b0);
    begin
      int v;
      read_y(2, 1, v);
      chk("R7 arithmetic shift", v, 1);
    end

    // R6: full-scale terms saturate accumulator and difference
    for (int j = 0; j < ROWS; j++) begin
      for (int i = 0; i < ROWS; i++) a_m[j][i] = 127;
      for (int k = 0; k < N; k++) begin y_m[j][k] = 32767; c_m[j][k] = -32768; end
    end
    load_all();
    run_pass(1'b0, 1'b0);
    begin
      int v;
      read_y(0, 0, v);
      chk("R6 saturating accumulate", v, 24576);
    end

    // R3 and R4: start and load offered mid-pass are ignored
    fill(VEC[1]);
    load_all();
    model();
    run_pass(1'b1, 1'b1);
    compare_all("R3 R4 mid-pass start and load ignored");
    repeat (3) begin
      @(negedge clk);
      chk("R3 no extra pass", int'(busy), 0);
    end

    summary();
  end
endmodule